// File: doc/BRIEF.md
# Nibble Entry Register with Marker-Bit Fill Detection

This block is the capture stage at the front of a first-in first-out stack. It gathers one 4-bit word in one of two ways. A parallel strobe copies a whole nibble in a single cycle. Alternatively, four single bits are shifted in on the falling edges of a serial strobe. Once a word is complete, an active-low status output (`not_full` going low) tells the writer to stop. The downstream stack takes the word by raising `take` for one cycle. The register then re-arms itself for the next word.

Word completion is detected without a bit counter. On re-arm, a single 1 (the marker) is placed in the top data bit, and every serial shift moves it one place down the chain. When it drops out of the bottom data bit into a fifth flip-flop, that flip-flop (the fill flag) marks the register as full. A three-state controller issues one command per cycle to the datapath. The commands are HOLD, INIT, LOAD and SHIFT.

The controller states are:
- EMPTY: armed, with no bit received.
- FILLING: some serial bits have been received.
- FULL: the fill flag is set.

The controller transitions are:
- EMPTY→FULL on a parallel load.
- EMPTY→FILLING on a shift.
- FILLING→FILLING on a shift that does not yet complete the word.
- FILLING→FULL on a parallel load, or on the shift that moves the marker out of the bottom bit.
- FULL→EMPTY on `take`.

All inputs are synchronous to `clk`. The serial strobe is registered once so that its falling edge can be detected.

Top module: `nibble_entry_reg`

## Requirements
- R1: After reset, `word_out` is 4'b1000 and `not_full` is 1. Bit 3 holds the marker, and the other bits and the fill flag are clear.
- R2: When `not_full` is 1 and `load_par` is high at a clock edge, the next cycle shows `word_out` equal to the sampled `par_din` and `not_full` at 0. This holds even when some serial bits have already been received.
- R3: The shift condition is met at a clock edge where `ser_strobe` is sampled 0, its previous sample was 1, `ser_en_n` is 0 and `not_full` is 1. At that edge, `ser_din` enters bit 3, bits 3..1 move down one place, and bit 0 moves into the fill flag.
- R4: A falling edge of `ser_strobe` while `ser_en_n` is 1, a rising edge, and a steady strobe level all leave `word_out` and `not_full` unchanged.
- R5: `not_full` stays 1 after the first three shifts and drops to 0 on the fourth shift. The first bit received is then in bit 0 and the last bit in bit 3.
- R6: While `not_full` is 0 (and `take` is low), serial strobe edges and parallel loads leave `word_out` and `not_full` unchanged.
- R7: When `take` is 1 at an edge where `not_full` is 0, the next cycle shows `word_out` = 4'b1000 and `not_full` = 1. When `take` is 1 while `not_full` is 1, it has no effect.
- R8: If a parallel load and the shift condition fall on the same edge, the parallel load wins and `word_out` equals `par_din`. This is a protocol violation by the writer.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_par | input | 1 | Parallel load strobe, active high |
| par_din | input | 4 | Parallel data word |
| ser_din | input | 1 | Serial data bit |
| ser_strobe | input | 1 | Serial shift strobe; a falling edge shifts |
| ser_en_n | input | 1 | Serial enable, active low |
| take | input | 1 | Downstream accept; hands the word off when full |
| word_out | output | 4 | Register contents, bit 3 down to bit 0 |
| not_full | output | 1 | High while a word can still be written |

## Verification
Every result is registered, so each effect of a stimulus sampled at edge k appears on `word_out` and `not_full` just after edge k. For a serial strobe, the shift happens at the first edge that samples the strobe low after a high sample. The bench drives inputs at the falling clock edge and samples outputs at the next falling edge, so exactly one rising edge lies between every stimulus and its check. Expected words come from a five-bit bench model of the shift chain. The bench sweeps all 16 parallel words and all 16 serial patterns, and checks the partial contents after each of the four shifts.

// File: rtl/nibble_entry_pkg.sv
package nibble_entry_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY   = 2'd0,
        ST_FILLING = 2'd1,
        ST_FULL    = 2'd2
    } fill_state_t;

    typedef enum logic [1:0] {
        CMD_HOLD  = 2'd0,
        CMD_INIT  = 2'd1,
        CMD_LOAD  = 2'd2,
        CMD_SHIFT = 2'd3
    } dp_cmd_t;

endpackage

// File: rtl/nibble_strobe_edge.sv
module nibble_strobe_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_in,
    output logic fall_pulse
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= strobe_in;
    end

    assign fall_pulse = prev_q & ~strobe_in;

    // R4: a detected edge never lasts two cycles
    property p_single_pulse;
        @(posedge clk) disable iff (!rst_n) fall_pulse |=> !fall_pulse;
    endproperty
    assert_edge_single_cycle_R4: assert property (p_single_pulse);

endmodule

// File: rtl/nibble_fill_ctrl.sv
module nibble_fill_ctrl
    import nibble_entry_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     load_req,
    input  logic     shift_req,
    input  logic     take_req,
    input  logic     marker_at_bottom,
    output dp_cmd_t  cmd,
    output logic     is_full
);
    fill_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (load_req)       state_d = ST_FULL;
                else if (shift_req) state_d = ST_FILLING;
            end
            ST_FILLING: begin
                if (load_req)       state_d = ST_FULL;
                else if (shift_req) state_d = marker_at_bottom ? ST_FULL : ST_FILLING;
            end
            ST_FULL: begin
                if (take_req)       state_d = ST_EMPTY;
            end
            default:                state_d = ST_EMPTY;
        endcase
    end

    always_comb begin
        cmd = CMD_HOLD;
        unique case (state_q)
            ST_EMPTY, ST_FILLING: begin
                if (load_req)       cmd = CMD_LOAD;
                else if (shift_req) cmd = CMD_SHIFT;
            end
            ST_FULL: begin
                if (take_req)       cmd = CMD_INIT;
            end
            default:                cmd = CMD_INIT;
        endcase
    end

    assign is_full = (state_q == ST_FULL);

    // R8: a load always beats a simultaneous shift
    property p_load_wins;
        @(posedge clk) disable iff (!rst_n)
            (load_req && shift_req && !is_full) |-> (cmd == CMD_LOAD);
    endproperty
    assert_load_priority_R8: assert property (p_load_wins);

    // R6: nothing but a take leaves the full state
    property p_full_sticky;
        @(posedge clk) disable iff (!rst_n)
            (is_full && !take_req) |=> is_full;
    endproperty
    assert_full_sticky_R6: assert property (p_full_sticky);

endmodule

// File: rtl/nibble_shift_path.sv
module nibble_shift_path
    import nibble_entry_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  dp_cmd_t      cmd,
    input  logic [W-1:0] par_in,
    input  logic         ser_in,
    output logic [W-1:0] bits,
    output logic         fill_flag
);
    localparam logic [W-1:0] ARMED = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] shifted;

    genvar gi;
    generate
        for (gi = 0; gi < W; gi++) begin : g_chain
            if (gi == W-1) begin : g_top
                assign shifted[gi] = ser_in;
            end else begin : g_mid
                assign shifted[gi] = bits[gi+1];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bits      <= ARMED;
            fill_flag <= 1'b0;
        end else begin
            unique case (cmd)
                CMD_INIT: begin
                    bits      <= ARMED;
                    fill_flag <= 1'b0;
                end
                CMD_LOAD: begin
                    bits      <= par_in;
                    fill_flag <= 1'b1;
                end
                CMD_SHIFT: begin
                    bits      <= shifted;
                    fill_flag <= bits[0];
                end
                default: ;
            endcase
        end
    end

    // R3: one shift moves every bit one place down
    property p_shift_move;
        @(posedge clk) disable iff (!rst_n)
            (cmd == CMD_SHIFT) |=>
                (bits == {$past(ser_in), $past(bits[W-1:1])}) && (fill_flag == $past(bits[0]));
    endproperty
    assert_shift_move_R3: assert property (p_shift_move);

    // R6: contents frozen while full and no re-arm is commanded
    property p_frozen;
        @(posedge clk) disable iff (!rst_n)
            (fill_flag && cmd != CMD_INIT) |=> ($stable(bits) && fill_flag);
    endproperty
    assert_frozen_when_full_R6: assert property (p_frozen);

endmodule

// File: rtl/nibble_entry_reg.sv
module nibble_entry_reg
    import nibble_entry_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_par,
    input  logic [W-1:0] par_din,
    input  logic         ser_din,
    input  logic         ser_strobe,
    input  logic         ser_en_n,
    input  logic         take,
    output logic [W-1:0] word_out,
    output logic         not_full
);
    localparam logic [W-1:0] ARMED = {1'b1, {(W-1){1'b0}}};

    logic    fall;
    logic    shift_req;
    logic    ctrl_full;
    logic    fill_flag;
    logic [W-1:0] bits;
    dp_cmd_t cmd;

    nibble_strobe_edge u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe_in  (ser_strobe),
        .fall_pulse (fall)
    );

    assign shift_req = fall & ~ser_en_n;

    nibble_fill_ctrl u_ctrl (
        .clk              (clk),
        .rst_n            (rst_n),
        .load_req         (load_par),
        .shift_req        (shift_req),
        .take_req         (take),
        .marker_at_bottom (bits[0]),
        .cmd              (cmd),
        .is_full          (ctrl_full)
    );

    nibble_shift_path #(.W(W)) u_path (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd       (cmd),
        .par_in    (par_din),
        .ser_in    (ser_din),
        .bits      (bits),
        .fill_flag (fill_flag)
    );

    assign word_out = bits;
    assign not_full = ~fill_flag;

    // R5: controller state and marker flag agree at all times
    property p_state_matches_flag;
        @(posedge clk) disable iff (!rst_n) ctrl_full == fill_flag;
    endproperty
    assert_state_matches_flag_R5: assert property (p_state_matches_flag);

    // R2: parallel load captures the word and signals full
    property p_parallel_load;
        @(posedge clk) disable iff (!rst_n)
            (load_par && not_full) |=> (!not_full && word_out == $past(par_din));
    endproperty
    assert_parallel_load_R2: assert property (p_parallel_load);

    // R7: hand-off re-arms the register
    property p_take_rearm;
        @(posedge clk) disable iff (!rst_n)
            (take && !not_full) |=> (not_full && word_out == ARMED);
    endproperty
    assert_take_rearm_R7: assert property (p_take_rearm);

endmodule

// File: tb/test_nibble_entry_reg.sv
`timescale 1ns/1ps
module test_nibble_entry_reg;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load_par = 1'b0;
    logic [3:0] par_din = 4'd0;
    logic       ser_din = 1'b0;
    logic       ser_strobe = 1'b0;
    logic       ser_en_n = 1'b0;
    logic       take = 1'b0;
    logic [3:0] word_out;
    logic       not_full;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    nibble_entry_reg i_nibble_entry_reg (
        .clk(clk), .rst_n(rst_n), .load_par(load_par), .par_din(par_din),
        .ser_din(ser_din), .ser_strobe(ser_strobe), .ser_en_n(ser_en_n),
        .take(take), .word_out(word_out), .not_full(not_full)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [4:0] act, input logic [4:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: {not_full,word}=%b expected %b", tag, act, exp);
        end
    endtask

    // rising then falling strobe; the shift lands on the falling sample
    task automatic pulse(input logic b);
        ser_din = b;
        ser_strobe = 1'b1; step();
        ser_strobe = 1'b0; step();
    endtask

    task automatic do_take();
        take = 1'b1; step(); take = 1'b0;
    endtask

    initial begin
        logic [4:0] m;
        rst_n = 1'b0; step(); step();
        rst_n = 1'b1; step();
        chk("R1 reset", {not_full, word_out}, 5'b1_1000);

        // R7: take while not full is ignored
        do_take();
        chk("R7 take ignored when not full", {not_full, word_out}, 5'b1_1000);

        // R2, R6, R7: all parallel words
        for (int v = 0; v < 16; v++) begin
            load_par = 1'b1; par_din = v[3:0]; step(); load_par = 1'b0;
            chk("R2 parallel load", {not_full, word_out}, {1'b0, v[3:0]});
            pulse(~v[0]);
            chk("R6 serial edge while full", {not_full, word_out}, {1'b0, v[3:0]});
            load_par = 1'b1; par_din = ~v[3:0]; step(); load_par = 1'b0;
            chk("R6 load while full", {not_full, word_out}, {1'b0, v[3:0]});
            do_take();
            chk("R7 take re-arms", {not_full, word_out}, 5'b1_1000);
        end

        // R3, R5: all serial patterns, first bit is p[0]
        for (int p = 0; p < 16; p++) begin
            m = 5'b0_1000; // {fill flag, bit3..bit0}
            for (int k = 0; k < 4; k++) begin
                pulse(p[k]);
                m = {m[0], p[k], m[3:1]};
                if (k < 3)
                    chk("R3 partial shift", {not_full, word_out}, {~m[4], m[3:0]});
            end
            chk("R5 four shifts complete", {not_full, word_out}, {1'b0, p[3:0]});
            do_take();
        end

        // R4: disabled edge, rising edge, steady level
        ser_en_n = 1'b1; ser_din = 1'b1;
        ser_strobe = 1'b1; step();
        chk("R4 rising edge", {not_full, word_out}, 5'b1_1000);
        ser_strobe = 1'b0; step();
        chk("R4 disabled falling edge", {not_full, word_out}, 5'b1_1000);
        ser_en_n = 1'b0; step(); step();
        chk("R4 steady low", {not_full, word_out}, 5'b1_1000);

        // R2: load after two serial bits overrides them
        pulse(1'b1); pulse(1'b1);
        load_par = 1'b1; par_din = 4'b0101; step(); load_par = 1'b0;
        chk("R2 load mid-serial", {not_full, word_out}, 5'b0_0101);
        do_take();

        // R8: deliberate protocol violation, load and shift together
        ser_strobe = 1'b1; step();
        ser_din = 1'b1; ser_strobe = 1'b0; load_par = 1'b1; par_din = 4'b0110; step();
        load_par = 1'b0;
        chk("R8 load beats shift", {not_full, word_out}, 5'b0_0110);
        do_take();
        chk("R7 take after conflict", {not_full, word_out}, 5'b1_1000);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1500000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule